// File: doc/BRIEF.md
# CPU Processing-State Sequencer

This block is the lifecycle controller of a small CPU core. It tracks which of five processing states the core is in: reset, exception handling, program execution, bus released and program stop. It also drives the enables that let the rest of the core run, hand the bus to another master, or fetch an exception vector. Requests come from the reset pin, a watchdog overflow pulse, interrupt, trace and trap sources, an external bus master, the sleep instruction and a hardware-standby pin.

Exception handling is a short transient state. The sequencer raises a vector-fetch request together with a vector number and waits for the fetch to be acknowledged before it lets execution begin. Both a watchdog overflow and the end of hardware standby pass through the reset state. There they are held for a programmable number of cycles before reset exception handling starts, the same way it starts when the reset pin goes high.

Top module: `cpu_state_seq`

## Requirements
- R1: `state_code` reports reset=0, exception=1, execute=2, bus released=3 and stop=4. `exec_en` is high only in execute, `bus_grant` only in bus released, and `vec_req` only in exception.
- R2: While `res_n` is low the state is reset, entered asynchronously from any state. It stays there whatever the other inputs do.
- R3: `int_mask` is high in the reset and exception states and low in all others.
- R4: On the first clock edge with `res_n` high after a pin reset, the sequencer enters exception with `vec_num` = VEC_RESET (0).
- R5: A `wdt_ovf` pulse forces reset from any state and has the highest priority. The state then stays reset for HOLD_CYC+1 cycles before it moves to exception with vector 0. Other requests are ignored during this time.
- R6: In exception the state holds until `vec_done`, then moves to execute.
- R7: In execute, simultaneous requests are served in this order: watchdog, hardware standby, exception sources, bus request, sleep.
- R8: Among exception sources, trace (vector VEC_TRACE = 5) beats trap (vector VEC_TRAP = 8), and trap beats interrupt (vector taken from `irq_vec`).
- R9: Bus released returns to execute once `bus_req` drops. While the bus request is held, sleep and exception requests are ignored.
- R10: A `sleep_exec` strobe in execute enters stop. That stop is left only by `irq_req`, which moves to exception with `irq_vec`. Trap and trace are ignored there.
- R11: `hw_stby` enters stop from exception, execute, bus released or sleep-stop. While standby is held, interrupts are ignored. When it drops, the state goes to reset for HOLD_CYC+1 cycles and then to exception with vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Active-low reset pin, asynchronous assertion |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | VEC_W | Vector number of the pending interrupt |
| trace_req | input | 1 | Trace exception request |
| trap_req | input | 1 | Trap instruction request |
| bus_req | input | 1 | Bus request from another master |
| sleep_exec | input | 1 | Sleep instruction executed strobe |
| hw_stby | input | 1 | Hardware standby level |
| vec_done | input | 1 | Vector fetch completed |
| state_code | output | 3 | Current processing state code |
| exec_en | output | 1 | Instruction execution enable |
| bus_grant | output | 1 | Bus granted to the other master |
| vec_req | output | 1 | Vector fetch request |
| vec_num | output | VEC_W | Vector number to fetch |
| int_mask | output | 1 | Interrupts masked |

## Verification
The bench builds the block with HOLD_CYC = 3 and VEC_W = 6. The longer hold gives a four-cycle reset stretch after a watchdog overflow or after standby ends. This makes an off-by-one in the hold counter visible. The six-bit vector width lets an interrupt vector (9) be told apart from both the fixed trace and trap vectors. A table walks the sequencer through every state and every priority conflict. Directed cases then cover the asynchronous pin reset in mid-cycle, a watchdog overflow while the bus is granted, and standby arriving during a sleep-entered stop.

// File: rtl/cpu_state_seq.sv
module cpu_state_seq #(
  parameter int VEC_W     = 6,
  parameter int HOLD_CYC  = 2,
  parameter int VEC_RESET = 0,
  parameter int VEC_TRACE = 5,
  parameter int VEC_TRAP  = 8
) (
  input  logic             clk,
  input  logic             res_n,
  input  logic             wdt_ovf,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             trace_req,
  input  logic             trap_req,
  input  logic             bus_req,
  input  logic             sleep_exec,
  input  logic             hw_stby,
  input  logic             vec_done,
  output logic [2:0]       state_code,
  output logic             exec_en,
  output logic             bus_grant,
  output logic             vec_req,
  output logic [VEC_W-1:0] vec_num,
  output logic             int_mask
);
  localparam int CNT_W = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);

  typedef enum logic [2:0] {
    S_RST  = 3'd0,
    S_EXC  = 3'd1,
    S_RUN  = 3'd2,
    S_BUS  = 3'd3,
    S_STOP = 3'd4
  } pstate_e;

  pstate_e          st, st_n;
  logic [CNT_W-1:0] hold, hold_n;
  logic [VEC_W-1:0] vec, vec_n;
  logic             by_stby, by_stby_n;

  wire              exc_any = trace_req | trap_req | irq_req;
  logic [VEC_W-1:0] exc_vec;

  always_comb begin
    if (trace_req)     exc_vec = VEC_W'(VEC_TRACE);
    else if (trap_req) exc_vec = VEC_W'(VEC_TRAP);
    else               exc_vec = irq_vec;
  end

  always_comb begin
    st_n      = st;
    hold_n    = hold;
    vec_n     = vec;
    by_stby_n = by_stby;
    if (wdt_ovf) begin
      st_n      = S_RST;
      hold_n    = CNT_W'(HOLD_CYC);
      by_stby_n = 1'b0;
    end else begin
      case (st)
        S_RST: begin
          if (hold != '0) hold_n = hold - CNT_W'(1);
          else begin
            st_n  = S_EXC;
            vec_n = VEC_W'(VEC_RESET);
          end
        end
        S_EXC: begin
          if (hw_stby) begin
            st_n      = S_STOP;
            by_stby_n = 1'b1;
          end else if (vec_done) st_n = S_RUN;
        end
        S_RUN: begin
          if (hw_stby) begin
            st_n      = S_STOP;
            by_stby_n = 1'b1;
          end else if (exc_any) begin
            st_n  = S_EXC;
            vec_n = exc_vec;
          end else if (bus_req) st_n = S_BUS;
          else if (sleep_exec) begin
            st_n      = S_STOP;
            by_stby_n = 1'b0;
          end
        end
        S_BUS: begin
          if (hw_stby) begin
            st_n      = S_STOP;
            by_stby_n = 1'b1;
          end else if (!bus_req) st_n = S_RUN;
        end
        S_STOP: begin
          if (by_stby) begin
            if (!hw_stby) begin
              st_n      = S_RST;
              hold_n    = CNT_W'(HOLD_CYC);
              by_stby_n = 1'b0;
            end
          end else if (hw_stby) by_stby_n = 1'b1;
          else if (irq_req) begin
            st_n  = S_EXC;
            vec_n = irq_vec;
          end
        end
        default: st_n = S_RST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      st      <= S_RST;
      hold    <= '0;
      vec     <= VEC_W'(VEC_RESET);
      by_stby <= 1'b0;
    end else begin
      st      <= st_n;
      hold    <= hold_n;
      vec     <= vec_n;
      by_stby <= by_stby_n;
    end
  end

  assign state_code = st;
  assign exec_en    = (st == S_RUN);
  assign bus_grant  = (st == S_BUS);
  assign vec_req    = (st == S_EXC);
  assign vec_num    = vec;
  assign int_mask   = (st == S_RST) || (st == S_EXC);
endmodule

// File: rtl/cpu_state_seq_chk.sv
module cpu_state_seq_chk (
  input logic       clk,
  input logic       res_n,
  input logic       wdt_ovf,
  input logic       bus_req,
  input logic       hw_stby,
  input logic       vec_done,
  input logic [2:0] state_code,
  input logic       int_mask
);
  // R2
  always @(posedge clk) begin
    if (!res_n) pin_reset_chk: assert (state_code == 3'd0);
  end

  // R3
  reset_masked_chk: assert property (@(posedge clk) disable iff (!res_n)
    (state_code == 3'd0) |-> int_mask);

  // R5
  wdt_force_chk: assert property (@(posedge clk) disable iff (!res_n)
    wdt_ovf |=> (state_code == 3'd0));

  // R6
  exc_exit_chk: assert property (@(posedge clk) disable iff (!res_n)
    (state_code == 3'd1 && vec_done && !wdt_ovf && !hw_stby) |=> (state_code == 3'd2));

  // R9
  bus_return_chk: assert property (@(posedge clk) disable iff (!res_n)
    (state_code == 3'd3 && !bus_req && !wdt_ovf && !hw_stby) |=> (state_code == 3'd2));

  // R11
  stby_entry_chk: assert property (@(posedge clk) disable iff (!res_n)
    (hw_stby && !wdt_ovf && state_code != 3'd0) |=> (state_code == 3'd4));

  // R4
  reset_exit_chk: assert property (@(posedge clk) disable iff (!res_n)
    (state_code == 3'd0) |=> (state_code == 3'd0 || state_code == 3'd1));
endmodule

bind cpu_state_seq cpu_state_seq_chk chk_i (
  .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .bus_req(bus_req),
  .hw_stby(hw_stby), .vec_done(vec_done), .state_code(state_code),
  .int_mask(int_mask)
);

// File: tb/cpu_state_seq_tb_top.sv
`timescale 1ns/1ps
module cpu_state_seq_tb_top;
  localparam int VW = 6;
  localparam int HOLD = 3;
  localparam logic [VW-1:0] IRQV = 6'd9;

  logic clk = 1'b0;
  logic res_n = 1'b0;
  logic wdt_ovf = 0, irq_req = 0, trace_req = 0, trap_req = 0;
  logic bus_req = 0, sleep_exec = 0, hw_stby = 0, vec_done = 0;
  logic [2:0] state_code;
  logic exec_en, bus_grant, vec_req, int_mask;
  logic [VW-1:0] vec_num;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cpu_state_seq #(.VEC_W(VW), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .irq_req(irq_req),
    .irq_vec(IRQV), .trace_req(trace_req), .trap_req(trap_req),
    .bus_req(bus_req), .sleep_exec(sleep_exec), .hw_stby(hw_stby),
    .vec_done(vec_done), .state_code(state_code), .exec_en(exec_en),
    .bus_grant(bus_grant), .vec_req(vec_req), .vec_num(vec_num),
    .int_mask(int_mask)
  );

  // inputs {wdt, stby, trace, trap, irq, breq, sleep, vdone}, next state, vector
  localparam int NROW = 33;
  localparam logic [16:0] TBL [NROW] = '{
    {8'b00000000, 3'd1, 6'd0}, {8'b00000000, 3'd1, 6'd0},
    {8'b00000001, 3'd2, 6'd0}, {8'b00000000, 3'd2, 6'd0},
    {8'b00000100, 3'd3, 6'd0}, {8'b00000100, 3'd3, 6'd0},
    {8'b00000000, 3'd2, 6'd0}, {8'b00001000, 3'd1, 6'd9},
    {8'b00000001, 3'd2, 6'd9}, {8'b00010110, 3'd1, 6'd8},
    {8'b00000001, 3'd2, 6'd8}, {8'b00000110, 3'd3, 6'd8},
    {8'b00000010, 3'd2, 6'd8}, {8'b00000010, 3'd4, 6'd8},
    {8'b00010000, 3'd4, 6'd8}, {8'b00001000, 3'd1, 6'd9},
    {8'b00000001, 3'd2, 6'd9}, {8'b01101000, 3'd4, 6'd9},
    {8'b01001000, 3'd4, 6'd9}, {8'b00000000, 3'd0, 6'd9},
    {8'b00000000, 3'd0, 6'd9}, {8'b00000000, 3'd0, 6'd9},
    {8'b00000000, 3'd0, 6'd9}, {8'b00000000, 3'd1, 6'd0},
    {8'b00000001, 3'd2, 6'd0}, {8'b11100000, 3'd0, 6'd0},
    {8'b00100000, 3'd0, 6'd0}, {8'b00000000, 3'd0, 6'd0},
    {8'b00000000, 3'd0, 6'd0}, {8'b00000000, 3'd1, 6'd0},
    {8'b00000001, 3'd2, 6'd0}, {8'b00111000, 3'd1, 6'd5},
    {8'b00000001, 3'd2, 6'd5}
  };

  function automatic string row_tag(int r);
    if (r < 2)        return "R4";
    if (r < 4)        return "R6";
    if (r < 7)        return "R9";
    if (r < 9)        return "R8";
    if (r == 9)       return "R7";
    if (r == 10)      return "R6";
    if (r == 11)      return "R7";
    if (r == 12)      return "R9";
    if (r < 16)       return "R10";
    if (r == 16)      return "R6";
    if (r < 24)       return "R11";
    if (r == 24)      return "R6";
    if (r < 30)       return "R5";
    if (r == 31)      return "R8";
    return "R6";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic look(string tag, logic [2:0] es, logic [VW-1:0] ev);
    check(tag, state_code, es);
    check("R1", exec_en, es == 3'd2);
    check("R1", bus_grant, es == 3'd3);
    check("R1", vec_req, es == 3'd1);
    check("R3", int_mask, es <= 3'd1);
    if (es == 3'd1) check(tag, vec_num, ev);
  endtask

  task automatic step(logic [7:0] in, logic [2:0] es, logic [VW-1:0] ev, string tag);
    @(negedge clk);
    {wdt_ovf, hw_stby, trace_req, trap_req, irq_req, bus_req, sleep_exec, vec_done} = in;
    @(posedge clk);
    #2;
    look(tag, es, ev);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2 reset held with requests present
    repeat (2) @(posedge clk);
    #2;
    look("R2", 3'd0, '0);
    step(8'b00111111, 3'd0, '0, "R2");
    // R4 release
    @(negedge clk);
    {wdt_ovf, hw_stby, trace_req, trap_req, irq_req, bus_req, sleep_exec, vec_done} = '0;
    res_n = 1'b1;
    for (int r = 0; r < NROW; r++)
      step(TBL[r][16:9], TBL[r][8:6], TBL[r][5:0], row_tag(r));

    // R5 watchdog while bus granted
    step(8'b00000100, 3'd3, '0, "R9");
    step(8'b10000100, 3'd0, '0, "R5");
    step(8'b00000000, 3'd0, '0, "R5");
    step(8'b00000000, 3'd0, '0, "R5");
    step(8'b00000000, 3'd0, '0, "R5");
    step(8'b00000000, 3'd1, '0, "R5");
    step(8'b00000001, 3'd2, '0, "R6");
    // R11 standby arriving in sleep-entered stop
    step(8'b00000010, 3'd4, '0, "R10");
    step(8'b01000000, 3'd4, '0, "R11");
    step(8'b01001000, 3'd4, '0, "R11");
    step(8'b00000000, 3'd0, '0, "R11");
    step(8'b00000000, 3'd0, '0, "R11");
    step(8'b00000000, 3'd0, '0, "R11");
    step(8'b00000000, 3'd0, '0, "R11");
    step(8'b00000000, 3'd1, '0, "R11");
    step(8'b00000001, 3'd2, '0, "R6");
    // R2 asynchronous pin reset mid-cycle
    @(negedge clk);
    res_n = 1'b0;
    #1;
    look("R2", 3'd0, '0);
    step(8'b00001101, 3'd0, '0, "R2");
    step(8'b00001101, 3'd0, '0, "R2");
    @(negedge clk);
    {wdt_ovf, hw_stby, trace_req, trap_req, irq_req, bus_req, sleep_exec, vec_done} = 8'b00000100;
    res_n = 1'b1;
    @(posedge clk);
    #2;
    look("R4", 3'd1, '0);
    step(8'b00000100, 3'd1, '0, "R6");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule